// File: doc/BRIEF.md
# Walsh-Spectrum Test Stream Regenerator

This block takes one stored test bit-stream of N bits, the sequence of values that a single circuit input receives over N test vectors, and produces a new stream of the same length. The new stream keeps the strong spectral content of the original and scrambles the weak content. Bits are first mapped to bipolar values. A sequential radix-2 butterfly then computes the stream's Walsh coefficients in natural (Sylvester) Hadamard order. Each coefficient is classified as essential or as noise by its power, and each noise coefficient is replaced by a small pseudo-random value. A second pass through the same butterfly applies the inverse transform, and the sign of each result gives one output bit.

The stream is loaded one bit per cycle through a serial port while the block is idle. A start pulse launches a run and also captures a 16-bit seed for the pseudo-random source. The regenerated stream leaves serially with a valid flag, and a one-cycle done pulse closes the run. A new stream can be loaded, or a new start issued, as soon as done is seen. Calling the block repeatedly with different seeds yields a family of streams that share the dominant Walsh components of the original.

Top module: `wp_gen`

## Requirements
- R1: While reset is active, and after it is released until a start is accepted, out_valid and done stay low. A reset applied in the middle of a run abandons the run, and no output follows.
- R2: While idle and with no start present, each cycle with load_en high stores load_bit as stream bit i. The index i begins at 0 after reset and after every accepted start, and rises by one per stored bit. load_en has no effect while a run is in progress.
- R3: start is accepted only while idle. A start (and its seed) that arrives during a run, including during the cycle of the last output bit, is ignored. It neither restarts the run nor changes its result.
- R4: Stream bit value 1 counts as +1 and value 0 counts as -1. Coefficient k is c_k = sum over i of (-1)^popcount(i AND k) times b_i.
- R5: Coefficient k is essential when k = 0 or when c_k squared is greater than N. An essential coefficient is used unchanged in reconstruction.
- R6: Every other coefficient is replaced by a perturbation value. Let r be the low 6 bits of the pseudo-random state. If r >= 45, r is reduced by 45, and the value is r - 22. This gives the range -22..+22 for N = 128, that is twice the integer square root of N.
- R7: The pseudo-random state is loaded from seed when a start is accepted, and a zero seed loads the value 1. It advances once per coefficient index in the order 0 to N-1, after that index has used it. The next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R8: Output bit i is 1 when s_i = sum over k of (-1)^popcount(i AND k) times c'_k is zero or positive, and 0 otherwise. Here c'_k is the coefficient after R5 and R6.
- R9: out_valid is high for exactly N consecutive cycles, carrying bits 0 to N-1 in order. The first bit appears 1024 clock edges after the edge that accepts start (for N = 128).
- R10: done is high for exactly one cycle, the cycle directly after the last output bit, with out_valid low. A start present in that cycle is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Store load_bit at the next stream index (idle only) |
| load_bit | input | 1 | Serial stream bit to store |
| start | input | 1 | Begin a run (idle only) |
| seed | input | 16 | Pseudo-random seed captured with start |
| out_valid | output | 1 | Regenerated bit present on out_bit |
| out_bit | output | 1 | Regenerated stream bit, index order |
| done | output | 1 | One-cycle pulse after the last output bit |

## Verification
Two events can share one clock cycle: the done pulse that closes a run and the start of the next run. A start can also arrive while the final output bit is still being presented. The bench drives start exactly in the cycle where done is observed high and expects a fresh run with exact output latency. It also drives start in the cycle of the last output bit and then expects a long period with no output at all. Seeds injected mid-run and serial loads attempted while busy are judged by comparing the full regenerated stream against a model computed from direct Hadamard sums.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FWD  = 3'd1,
    ST_CLS  = 3'd2,
    ST_INV  = 3'd3,
    ST_OUT  = 3'd4
  } wp_state_e;

  // integer square root, used to size the perturbation range
  function automatic int isqrt(input int v);
    int r;
    r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

endpackage

// File: rtl/wp_lfsr.sv
module wp_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] q, d;

  always_comb begin
    d = q;
    if (load) begin
      d = (seed == '0) ? W'(1) : seed;
    end else if (step) begin
      d = {q[W-2:0], ^(q & TAPS)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= W'(1);
    else        q <= d;
  end

  assign state = q;

endmodule

// File: rtl/wp_bfly.sv
module wp_bfly #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] sum,
  output logic signed [W-1:0] dif
);

  assign sum = a + b;
  assign dif = a - b;

endmodule

// File: rtl/wp_coef_sel.sv
module wp_coef_sel #(
  parameter int N    = 128,
  parameter int CW   = 9,
  parameter int AW   = 16,
  parameter int PMAX = 22,
  parameter int SPAN = 45,
  parameter int RB   = 6
) (
  input  logic          is_dc,
  input  logic [CW-1:0] coef,
  input  logic [RB-1:0] rnd,
  output logic [AW-1:0] dout
);

  localparam int SQW = 2 * CW;

  logic signed [SQW-1:0] cext;
  logic signed [SQW-1:0] sq;
  logic [RB-1:0]         fold;
  logic                  essential;

  always_comb begin
    cext      = $signed({{CW{coef[CW-1]}}, coef});
    sq        = cext * cext;
    essential = is_dc | (sq > $signed(SQW'(N)));
    fold      = (rnd >= RB'(SPAN)) ? (rnd - RB'(SPAN)) : rnd;
    if (essential) dout = {{(AW-CW){coef[CW-1]}}, coef};
    else           dout = {{(AW-RB){1'b0}}, fold} - AW'(PMAX);
  end

endmodule

// File: rtl/wp_gen.sv
module wp_gen #(
  parameter int                 N         = 128,
  parameter int                 LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              load_bit,
  input  logic              start,
  input  logic [LFSR_W-1:0] seed,
  output logic              out_valid,
  output logic              out_bit,
  output logic              done
);
  import wp_pkg::*;

  localparam int LOG2N = $clog2(N);
  localparam int CW    = LOG2N + 2;
  localparam int AW    = 2 * LOG2N + 2;
  localparam int PW    = $clog2(LOG2N + 1);
  localparam int PMAX  = 2 * isqrt(N);
  localparam int SPAN  = 2 * PMAX + 1;
  localparam int RB    = $clog2(SPAN);

  localparam logic [LOG2N-1:0] PAIR_LAST = LOG2N'(N / 2 - 1);
  localparam logic [LOG2N-1:0] IDX_LAST  = LOG2N'(N - 1);
  localparam logic [LOG2N-1:0] ONE_IDX   = LOG2N'(1);
  localparam logic [PW-1:0]    PASS_LAST = PW'(LOG2N - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  wp_state_e         state_q, state_d;
  logic [PW-1:0]     pass_q, pass_d;
  logic [LOG2N-1:0]  cnt_q, cnt_d;
  logic [LOG2N-1:0]  ptr_q, ptr_d;
  logic              done_q, done_d;

  logic [AW-1:0]     mem_q [N];

  logic [LOG2N-1:0]  hbit, lo_idx, hi_idx;
  logic signed [AW-1:0] bf_sum, bf_dif;
  logic [AW-1:0]     sel_dat;
  logic [LFSR_W-1:0] lfsr_q;
  logic              lfsr_load, lfsr_step;

  logic              we_a, we_b;
  logic [LOG2N-1:0]  wa_idx, wb_idx;
  logic [AW-1:0]     wa_dat, wb_dat;

  logic              busy, in_fwd;

  // butterfly addressing: insert a zero at bit position pass into the pair count
  always_comb begin
    hbit   = ONE_IDX << pass_q;
    lo_idx = ((cnt_q >> pass_q) << (pass_q + 1'b1)) | (cnt_q & (hbit - 1'b1));
    hi_idx = lo_idx | hbit;
  end

  wp_bfly #(.W(AW)) u_bfly (
    .a   (mem_q[lo_idx]),
    .b   (mem_q[hi_idx]),
    .sum (bf_sum),
    .dif (bf_dif)
  );

  wp_coef_sel #(
    .N(N), .CW(CW), .AW(AW), .PMAX(PMAX), .SPAN(SPAN), .RB(RB)
  ) u_sel (
    .is_dc (cnt_q == '0),
    .coef  (mem_q[cnt_q][CW-1:0]),
    .rnd   (lfsr_q[RB-1:0]),
    .dout  (sel_dat)
  );

  wp_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (lfsr_load),
    .seed  (seed),
    .step  (lfsr_step),
    .state (lfsr_q)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pass_d    = pass_q;
    cnt_d     = cnt_q;
    ptr_d     = ptr_q;
    done_d    = 1'b0;
    lfsr_load = 1'b0;
    lfsr_step = 1'b0;
    we_a      = 1'b0;
    we_b      = 1'b0;
    wa_idx    = lo_idx;
    wb_idx    = hi_idx;
    wa_dat    = bf_sum;
    wb_dat    = bf_dif;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d   = ST_FWD;
          pass_d    = '0;
          cnt_d     = '0;
          ptr_d     = '0;
          lfsr_load = 1'b1;
        end else if (load_en) begin
          we_a   = 1'b1;
          wa_idx = ptr_q;
          wa_dat = load_bit ? AW'(1) : '1;
          ptr_d  = ptr_q + 1'b1;
        end
      end
      ST_FWD, ST_INV: begin
        we_a  = 1'b1;
        we_b  = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == PAIR_LAST) begin
          cnt_d = '0;
          if (pass_q == PASS_LAST) begin
            pass_d  = '0;
            state_d = (state_q == ST_FWD) ? ST_CLS : ST_OUT;
          end else begin
            pass_d = pass_q + 1'b1;
          end
        end
      end
      ST_CLS: begin
        we_a      = 1'b1;
        wa_idx    = cnt_q;
        wa_dat    = sel_dat;
        lfsr_step = 1'b1;
        cnt_d     = cnt_q + 1'b1;
        if (cnt_q == IDX_LAST) begin
          cnt_d   = '0;
          state_d = ST_INV;
        end
      end
      ST_OUT: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == IDX_LAST) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      done_q  <= done_d;
    end
  end

  // value storage, write-enabled, no reset
  always_ff @(posedge clk) begin
    if (we_a) mem_q[wa_idx] <= wa_dat;
    if (we_b) mem_q[wb_idx] <= wb_dat;
  end

  assign out_valid = (state_q == ST_OUT);
  assign out_bit   = ~mem_q[cnt_q][AW-1];
  assign done      = done_q;
  assign busy      = (state_q != ST_IDLE);
  assign in_fwd    = (state_q == ST_FWD);

endmodule

// File: rtl/wp_gen_chk.sv
module wp_gen_chk #(
  parameter int N  = 128,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_valid,
  input logic          done,
  input logic          busy,
  input logic          in_fwd,
  input logic [LW-1:0] lfsr_q
);

  logic [$clog2(N):0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (done)      run_cnt <= '0;
    else if (out_valid) run_cnt <= run_cnt + 1'b1;
  end

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  a_r10_done_after_out: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid));

  a_r9_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (out_valid || done));

  a_r9_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == ($clog2(N)+1)'(N)));

  a_r7_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lfsr_q != '0));

  a_r3_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fwd && start) |=> $stable(lfsr_q));

endmodule

bind wp_gen wp_gen_chk #(.N(N), .LW(LFSR_W)) u_wp_gen_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .out_valid (out_valid),
  .done      (done),
  .busy      (busy),
  .in_fwd    (in_fwd),
  .lfsr_q    (lfsr_q)
);

// File: tb/test_wp_gen.sv
`timescale 1ns/1ps
module test_wp_gen;

  localparam int N       = 128;
  localparam int LAT     = 1025;   // negedge count of first out bit (1024 edges after accept)
  localparam int DONE_AT = 1153;
  localparam int NVEC    = 6;

  localparam logic [N-1:0] PAT [NVEC] = '{
    128'h0,
    {N{1'b1}},
    {32{4'hA}},
    {{64{1'b1}}, {64{1'b0}}},
    {16{8'h0F}},
    128'h3C5A_96E1_7B20_D48F_0193_E6C5_A2B7_5F18
  };
  localparam logic [15:0] SEEDS [NVEC] = '{
    16'hACE1, 16'h0000, 16'h1234, 16'hFFFF, 16'h8001, 16'h5A5A
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_en, load_bit, start;
  logic [15:0] seed;
  logic        out_valid, out_bit, done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  wp_gen i_wp_gen (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_bit(load_bit),
    .start(start), .seed(seed), .out_valid(out_valid), .out_bit(out_bit), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [N-1:0] p, input logic [15:0] sd);
    int c [N];
    int s, v;
    logic [15:0] l;
    logic [N-1:0] r;
    l = (sd == 16'h0) ? 16'h1 : sd;
    for (int k = 0; k < N; k++) begin
      s = 0;
      for (int i = 0; i < N; i++) begin
        v = p[i] ? 1 : -1;
        if ($countones(i & k) % 2 == 1) s -= v; else s += v;
      end
      c[k] = s;
    end
    for (int k = 0; k < N; k++) begin
      if (!(k == 0 || c[k] * c[k] > N)) begin
        v = int'(l[5:0]);
        if (v >= 45) v -= 45;
        c[k] = v - 22;
      end
      l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    end
    for (int i = 0; i < N; i++) begin
      s = 0;
      for (int k = 0; k < N; k++) begin
        if ($countones(i & k) % 2 == 1) s -= c[k]; else s += c[k];
      end
      r[i] = (s >= 0);
    end
    return r;
  endfunction

  task automatic load_stream(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) begin
      load_en  = 1'b1;
      load_bit = p[i];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
  endtask

  // issues start at the current negedge and observes until done
  task automatic run(input logic [15:0] sd, input int inj_at, input logic [15:0] inj_seed,
                     input bit inj_load, output logic [N-1:0] got, output int first_v,
                     output int nvalid, output int done_at);
    start = 1'b1;
    seed  = sd;
    @(negedge clk);
    start   = 1'b0;
    first_v = -1;
    nvalid  = 0;
    done_at = -1;
    got     = '0;
    for (int c = 1; c < 3000; c++) begin
      if (out_valid) begin
        if (first_v < 0) first_v = c;
        if (nvalid < N) got[nvalid] = out_bit;
        nvalid++;
      end
      if (done) begin
        done_at = c;
        break;
      end
      start = (c == inj_at);
      if (c == inj_at) seed = inj_seed;
      load_en  = inj_load && (c >= 10) && (c < 200);
      load_bit = c[0];
      @(negedge clk);
    end
    start   = 1'b0;
    load_en = 1'b0;
  endtask

  task automatic run_checked(input logic [N-1:0] p, input logic [15:0] sd, input int inj_at,
                             input logic [15:0] inj_seed, input bit inj_load, input string tag);
    logic [N-1:0] got, exp;
    int fv, nv, da;
    exp = model(p, sd);
    run(sd, inj_at, inj_seed, inj_load, got, fv, nv, da);
    check(fv == LAT, "R9 first bit latency", N'(fv), N'(LAT));
    check(nv == N, "R9 bit count", N'(nv), N'(N));
    check(da == DONE_AT, "R10 done timing", N'(da), N'(DONE_AT));
    check(got == exp, tag, got, exp);
    @(negedge clk);
    check(!done && !out_valid, "R10 done one cycle", N'({done, out_valid}), N'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] got;
    int fv, nv, da;
    bit quiet;

    rst_n = 1'b0; load_en = 1'b0; load_bit = 1'b0; start = 1'b0; seed = '0;
    repeat (5) @(negedge clk);
    check(!out_valid && !done, "R1 reset state", N'({out_valid, done}), N'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !done, "R1 idle after release", N'({out_valid, done}), N'(0));

    // table walk: R2 load, R4 R5 R6 R7 R8 content, R9 R10 timing
    for (int t = 0; t < NVEC; t++) begin
      load_stream(PAT[t]);
      run_checked(PAT[t], SEEDS[t], -1, 16'h0, 1'b0, "R2 R4 R5 R6 R7 R8 regenerated stream");
    end

    // R3: start with another seed during the forward pass is ignored
    load_stream(PAT[5]);
    run_checked(PAT[5], 16'h1357, 100, 16'hBEEF, 1'b0, "R3 start during run ignored");

    // R2: serial loads during a run have no effect
    load_stream(PAT[4]);
    run_checked(PAT[4], 16'h2468, -1, 16'h0, 1'b1, "R2 load during run ignored");

    // R3: start during the final output bit is ignored
    load_stream(PAT[2]);
    run_checked(PAT[2], 16'h0F0F, DONE_AT - 1, 16'h7777, 1'b0, "R3 late start data");
    quiet = 1'b1;
    for (int c = 0; c < 1100; c++) begin
      if (out_valid || done) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R3 late start left idle", N'(quiet), N'(1));

    // R10: start in the done cycle starts a new run at once
    load_stream(PAT[3]);
    run(16'h4321, -1, 16'h0, 1'b0, got, fv, nv, da);
    check(got == model(PAT[3], 16'h4321), "R8 stream before back-to-back", got, model(PAT[3], 16'h4321));
    check(done, "R10 done seen", N'(done), N'(1));
    run(16'h9999, -1, 16'h0, 1'b0, got, fv, nv, da);
    check(fv == LAT, "R10 back-to-back latency", N'(fv), N'(LAT));
    check(da == DONE_AT, "R10 back-to-back done", N'(da), N'(DONE_AT));
    @(negedge clk);

    // R1: reset mid-run abandons it
    load_stream(PAT[1]);
    start = 1'b1; seed = 16'h1111;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && !done, "R1 reset during run", N'({out_valid, done}), N'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    quiet = 1'b1;
    for (int c = 0; c < 1200; c++) begin
      if (out_valid || done) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R1 no output after reset", N'(quiet), N'(1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule